// File: doc/BRIEF.md
# Memory Security Attribution Checker

This block classifies every memory request of a small microcontroller into one of four security attributes and decides whether it may proceed. Each request carries an address, an access kind (instruction fetch, data read or data write) and the security state of the caller. The block returns three things. The first is the attribute of the region that holds the address. The second is a region number that test-target queries can report. The third is a verdict: permit, fault, or silent write drop.

There are fourteen regions, each bounded by a programmable 32-bit base and limit pair. The regions cover boot and application flash, data flash, boot ROM, SRAM, the non-volatile configuration rows, peripherals and the IO bus. A configuration port, assumed to be driven only by secure software, writes the bounds. A lock input freezes them.

Exempt regions are not judged by security state; their checks happen downstream. They are still execute-never. The configuration rows also carry a write rule for non-secure callers.

Top module: `sac_top`

## Requirements
- R1: After reset `valid_o` and `fault_o` are low, and the default bounds make flash (from 0x0000_0000) and SRAM (from 0x2000_0000) Secure: a non-secure access there faults with region numbers 1 and 9 respectively.
- R2: A request sampled with `req_valid_i` high produces `valid_o` high, with its results, exactly one clock later. `valid_o` is low after a cycle without a request, and `fault_o` is high only together with `valid_o`.
- R3: Attribute Secure (`attr_o`=0) permits any kind from the secure state (`req_secure_i`=1) and faults every non-secure access.
- R4: Attribute Non-Secure (`attr_o`=2) permits every access from either state.
- R5: Attribute Non-Secure Callable (`attr_o`=1) permits all secure accesses. From the non-secure state it permits fetches (`req_kind_i`=0) and faults reads (1) and writes (2). Kind 3 is treated as a read everywhere.
- R6: The boot ROM (index 7) is Secure and execute-only: only a secure fetch is permitted, and every data access faults.
- R7: Attribute Exempt (`attr_o`=3) is given to the peripheral (index 12) and IO-bus (index 13) regions. Any fetch there faults, and data accesses from either state pass.
- R8: The boot-configuration row (index 10) and the other configuration rows (index 11) are Exempt and execute-never, and secure callers may read and write them. Non-secure reads pass. A non-secure write to index 10 is dropped: `discard_o`=1 and `fault_o`=0. A non-secure write to index 11 faults. `discard_o` and `fault_o` are never both high.
- R9: Region numbers are indices 0..9 → 0x01..0x0A, in the order: secure boot flash, callable boot flash, secure app flash, callable app flash, non-secure app flash, secure data flash, non-secure data flash, boot ROM, secure SRAM, non-secure SRAM. Every Exempt or unmapped result reports 0x00.
- R10: An address outside every region is Secure with region number 0x00 and follows the Secure rule.
- R11: A region matches when base ≤ address ≤ limit, both ends inclusive. When regions overlap, the lowest index wins.
- R12: A write with `cfg_we_i`=1 loads `cfg_wdata_i` into the bound of region `cfg_idx_i`: the base when `cfg_limit_sel_i`=0, the limit when it is 1. The write is ignored while `lock_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_i | input | 1 | Freezes the region bounds while high |
| cfg_we_i | input | 1 | Bound write strobe |
| cfg_idx_i | input | 4 | Region index of the write |
| cfg_limit_sel_i | input | 1 | 0 writes the base, 1 writes the limit |
| cfg_wdata_i | input | 32 | Bound value |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 32 | Request address |
| req_kind_i | input | 2 | 0 fetch, 1 read, 2 write, 3 read |
| req_secure_i | input | 1 | Caller is in the secure state |
| valid_o | output | 1 | Results valid, one cycle after the request |
| attr_o | output | 2 | 0 Secure, 1 Non-Secure Callable, 2 Non-Secure, 3 Exempt |
| region_o | output | 8 | Region number, 0 when invalid |
| fault_o | output | 1 | Access not permitted |
| discard_o | output | 1 | Write silently dropped |

## Verification
The bench programs a map of fourteen separate windows with gaps between them. It then sweeps every region at its base, its middle and its limit, crossed with all four access kinds and both caller states. This separates the per-attribute rules from one another and catches off-by-one errors at the bounds. The address just below each base probes the unmapped default. A region is then moved so that it overlaps its neighbour; addresses inside and outside the overlap separate lowest-index priority from the highest-index alternative. A bound write under lock, followed by a probe that the write would have captured, shows whether the lock held.

// File: rtl/sac_pkg.sv
package sac_pkg;
  parameter int unsigned AW   = 32;
  parameter int unsigned NREG = 14;
  parameter int unsigned RNW  = 8;
  localparam int unsigned IW  = $clog2(NREG);

  localparam int unsigned RIDX_ROM     = 7;
  localparam int unsigned RIDX_BOOTCFG = 10;
  localparam int unsigned RIDX_NVM     = 11;
  localparam int unsigned NUMBERED     = 10;

  typedef enum logic [1:0] {ATTR_S = 2'd0, ATTR_NSC = 2'd1, ATTR_NS = 2'd2, ATTR_EX = 2'd3} attr_e;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_READ = 2'd1, ACC_WRITE = 2'd2, ACC_RSVD = 2'd3} acc_e;

  typedef struct packed {
    attr_e          attr;
    logic [RNW-1:0] rnum;
    logic           fault;
    logic           discard;
  } verdict_t;

  function automatic attr_e reg_attr(input int unsigned i);
    case (i)
      1, 3:          return ATTR_NSC;
      4, 6, 9:       return ATTR_NS;
      10, 11, 12, 13: return ATTR_EX;
      default:       return ATTR_S;
    endcase
  endfunction

  function automatic logic [RNW-1:0] reg_num(input int unsigned i);
    return (i < NUMBERED) ? RNW'(i + 1) : '0;
  endfunction

  // empty regions: base above limit
  function automatic logic [AW-1:0] def_base(input int unsigned i);
    case (i)
      0:  return 32'h0000_0000;
      2:  return 32'h0000_2000;
      5:  return 32'h0040_0000;
      7:  return 32'h0200_0000;
      8:  return 32'h2000_0000;
      10: return 32'h0080_C000;
      11: return 32'h0080_0000;
      12: return 32'h4000_0000;
      13: return 32'h6000_0000;
      default: return '1;
    endcase
  endfunction

  function automatic logic [AW-1:0] def_limit(input int unsigned i);
    case (i)
      0:  return 32'h0000_1FFF;
      2:  return 32'h0003_FFFF;
      5:  return 32'h0040_1FFF;
      7:  return 32'h0200_7FFF;
      8:  return 32'h2000_7FFF;
      10: return 32'h0080_C0FF;
      11: return 32'h0080_FFFF;
      12: return 32'h4FFF_FFFF;
      13: return 32'h6000_FFFF;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sac_cfg_regs.sv
module sac_cfg_regs
  import sac_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lock_i,
  input  logic                     we_i,
  input  logic [IW-1:0]            idx_i,
  input  logic                     limit_sel_i,
  input  logic [AW-1:0]            wdata_i,
  output logic [NREG-1:0][AW-1:0]  base_o,
  output logic [NREG-1:0][AW-1:0]  limit_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [AW-1:0] b_q, l_q;
    logic          sel;
    assign sel = we_i && !lock_i && (idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_q <= def_base(g);
        l_q <= def_limit(g);
      end else if (sel) begin
        if (limit_sel_i) l_q <= wdata_i;
        else             b_q <= wdata_i;
      end
    end
    assign base_o[g]  = b_q;
    assign limit_o[g] = l_q;
  end
endmodule

// File: rtl/sac_region_lookup.sv
module sac_region_lookup
  import sac_pkg::*;
(
  input  logic [AW-1:0]            addr_i,
  input  logic [NREG-1:0][AW-1:0]  base_i,
  input  logic [NREG-1:0][AW-1:0]  limit_i,
  output logic                     hit_o,
  output logic [IW-1:0]            idx_o
);
  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match[g] = (addr_i >= base_i[g]) && (addr_i <= limit_i[g]);
  end

  // lowest index wins
  always_comb begin
    hit_o = |match;
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/sac_access_rule.sv
module sac_access_rule
  import sac_pkg::*;
(
  input  logic          hit_i,
  input  logic [IW-1:0] idx_i,
  input  logic [1:0]    kind_i,
  input  logic          secure_i,
  output verdict_t      verdict_o
);
  logic fetch, write, is_rom, is_bootcfg, is_nvm;

  assign fetch      = (kind_i == ACC_FETCH);
  assign write      = (kind_i == ACC_WRITE);
  assign is_rom     = (idx_i == IW'(RIDX_ROM));
  assign is_bootcfg = (idx_i == IW'(RIDX_BOOTCFG));
  assign is_nvm     = (idx_i == IW'(RIDX_NVM));

  always_comb begin
    verdict_o.discard = 1'b0;
    if (!hit_i) begin
      verdict_o.attr  = ATTR_S;
      verdict_o.rnum  = '0;
      verdict_o.fault = !secure_i;
    end else begin
      verdict_o.attr = reg_attr(int'(idx_i));
      verdict_o.rnum = reg_num(int'(idx_i));
      unique case (verdict_o.attr)
        ATTR_S:   verdict_o.fault = !secure_i || (is_rom && !fetch);
        ATTR_NSC: verdict_o.fault = !secure_i && !fetch;
        ATTR_NS:  verdict_o.fault = 1'b0;
        default: begin
          verdict_o.fault = fetch || (!secure_i && write && is_nvm);
          verdict_o.discard = !fetch && !secure_i && write && is_bootcfg;
        end
      endcase
    end
  end
endmodule

// File: rtl/sac_top.sv
module sac_top
  import sac_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lock_i,
  input  logic                cfg_we_i,
  input  logic [IW-1:0]       cfg_idx_i,
  input  logic                cfg_limit_sel_i,
  input  logic [AW-1:0]       cfg_wdata_i,
  input  logic                req_valid_i,
  input  logic [AW-1:0]       req_addr_i,
  input  logic [1:0]          req_kind_i,
  input  logic                req_secure_i,
  output logic                valid_o,
  output logic [1:0]          attr_o,
  output logic [RNW-1:0]      region_o,
  output logic                fault_o,
  output logic                discard_o
);
  logic [NREG-1:0][AW-1:0] base_q, limit_q;
  logic                    hit;
  logic [IW-1:0]           idx;
  verdict_t                v_d, v_q;
  logic                    valid_q;

  sac_cfg_regs u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i), .we_i(cfg_we_i),
    .idx_i(cfg_idx_i), .limit_sel_i(cfg_limit_sel_i), .wdata_i(cfg_wdata_i),
    .base_o(base_q), .limit_o(limit_q)
  );

  sac_region_lookup u_lookup (
    .addr_i(req_addr_i), .base_i(base_q), .limit_i(limit_q),
    .hit_o(hit), .idx_o(idx)
  );

  sac_access_rule u_rule (
    .hit_i(hit), .idx_i(idx), .kind_i(req_kind_i),
    .secure_i(req_secure_i), .verdict_o(v_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      v_q     <= '{attr: ATTR_S, rnum: '0, fault: 1'b0, discard: 1'b0};
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) v_q <= v_d;
      else begin
        v_q.fault   <= 1'b0;
        v_q.discard <= 1'b0;
      end
    end
  end

  assign valid_o   = valid_q;
  assign attr_o    = v_q.attr;
  assign region_o  = v_q.rnum;
  assign fault_o   = v_q.fault;
  assign discard_o = v_q.discard;
endmodule

// File: rtl/sac_checker.sv
module sac_checker
  import sac_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    lock_i,
  input logic                    cfg_we_i,
  input logic                    req_valid_i,
  input logic [1:0]              req_kind_i,
  input logic [NREG-1:0][AW-1:0] base_q,
  input logic [NREG-1:0][AW-1:0] limit_q,
  input logic                    valid_o,
  input logic [1:0]              attr_o,
  input logic [RNW-1:0]          region_o,
  input logic                    fault_o,
  input logic                    discard_o
);
  p_valid_track_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!valid_o && !fault_o && !discard_o));
  p_ns_open_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && attr_o == ATTR_NS) |-> !fault_o);
  p_rom_xo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && region_o == RNW'(8) && $past(req_kind_i) != ACC_FETCH) |-> fault_o);
  p_exempt_xn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && attr_o == ATTR_EX && $past(req_kind_i) == ACC_FETCH) |-> fault_o);
  p_drop_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> (!fault_o && attr_o == ATTR_EX));
  p_exempt_num_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && attr_o == ATTR_EX) |-> region_o == '0);
  p_lock_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && lock_i) |=> ($stable(base_q) && $stable(limit_q)));
endmodule

bind sac_top sac_checker u_sac_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i), .cfg_we_i(cfg_we_i),
  .req_valid_i(req_valid_i), .req_kind_i(req_kind_i),
  .base_q(base_q), .limit_q(limit_q),
  .valid_o(valid_o), .attr_o(attr_o), .region_o(region_o),
  .fault_o(fault_o), .discard_o(discard_o)
);

// File: tb/sac_top_bench.sv
module sac_top_bench;
  logic        clk_i = 0, rst_ni = 0, lock_i = 0, cfg_we_i = 0, cfg_limit_sel_i = 0;
  logic [3:0]  cfg_idx_i = 0;
  logic [31:0] cfg_wdata_i = 0, req_addr_i = 0;
  logic        req_valid_i = 0, req_secure_i = 0;
  logic [1:0]  req_kind_i = 0;
  logic        valid_o, fault_o, discard_o;
  logic [1:0]  attr_o;
  logic [7:0]  region_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_base [14];
  logic [31:0] m_lim  [14];

  always #5 clk_i = ~clk_i;

  sac_top u_sac_top (.*);

  function automatic int m_attr(int i);
    if (i == 1 || i == 3) return 1;
    if (i == 4 || i == 6 || i == 9) return 2;
    if (i >= 10) return 3;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(int idx, bit lim, logic [31:0] d);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_idx_i = 4'(idx); cfg_limit_sel_i = lim; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic set_region(int idx, logic [31:0] b, logic [31:0] l);
    cfg_wr(idx, 0, b); cfg_wr(idx, 1, l);
    m_base[idx] = b; m_lim[idx] = l;
  endtask

  // issue, then sample one edge later
  task automatic probe(logic [31:0] a, int k, bit s);
    int hit_i, ea, er, ef, ed;
    bit fetch, wr;
    string tag;
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = a; req_kind_i = 2'(k); req_secure_i = s;
    @(negedge clk_i);
    req_valid_i = 0;
    fetch = (k == 0); wr = (k == 2);
    hit_i = -1;
    for (int i = 13; i >= 0; i--)
      if (a >= m_base[i] && a <= m_lim[i]) hit_i = i;
    ed = 0;
    if (hit_i < 0) begin
      ea = 0; er = 0; ef = !s; tag = "R10";
    end else begin
      ea = m_attr(hit_i);
      er = (hit_i < 10) ? hit_i + 1 : 0;
      case (ea)
        0: begin
          ef = !s || (hit_i == 7 && !fetch);
          tag = (hit_i == 7) ? "R6" : "R3";
        end
        1: begin ef = !s && !fetch; tag = "R5"; end
        2: begin ef = 0; tag = "R4"; end
        default: begin
          ef = fetch || (!s && wr && hit_i == 11);
          ed = (!fetch && !s && wr && hit_i == 10) ? 1 : 0;
          tag = (hit_i >= 12) ? "R7" : "R8";
        end
      endcase
    end
    chk("R2 valid", int'(valid_o), 1);
    chk(tag, int'(attr_o), ea);
    chk("R9 region", int'(region_o), er);
    chk(tag, int'(fault_o), ef);
    chk(tag, int'(discard_o), ed);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 14; i++) begin m_base[i] = '1; m_lim[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 fault", int'(fault_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 valid", int'(valid_o), 0);
    // default map: flash and SRAM secure
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = 32'h0000_0100; req_kind_i = 1; req_secure_i = 0;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R1 attr", int'(attr_o), 0);
    chk("R1 region", int'(region_o), 1);
    chk("R1 fault", int'(fault_o), 1);
    @(negedge clk_i);
    req_valid_i = 1; req_addr_i = 32'h2000_0100; req_kind_i = 2;
    @(negedge clk_i);
    req_valid_i = 0;
    chk("R1 region", int'(region_o), 9);
    chk("R1 fault", int'(fault_o), 1);
    @(negedge clk_i);
    chk("R2 idle valid", int'(valid_o), 0);
    chk("R2 idle fault", int'(fault_o), 0);

    // R12: program a disjoint map
    for (int i = 0; i < 14; i++)
      set_region(i, 32'((i + 1) << 24), 32'((i + 1) << 24) + 32'h0FFF);

    // R3..R11 sweep
    for (int i = 0; i < 14; i++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 4; k++)
          for (int s = 0; s < 2; s++) begin
            logic [31:0] a;
            case (p)
              0: a = m_base[i];
              1: a = m_base[i] + 32'h0800;
              2: a = m_lim[i];
              default: a = m_base[i] - 1;   // R11 gap below base
            endcase
            probe(a, k, s[0]);
          end
    probe(32'hF000_0000, 1, 0);   // R10 far unmapped
    probe(32'hF000_0000, 2, 1);

    // R11 overlap: index 3 reaches into index 2
    set_region(3, 32'h0300_0800, 32'h0400_0FFF);
    for (int k = 0; k < 3; k++) begin
      probe(32'h0300_0900, k, 0);
      probe(32'h0300_0FFF, k, 1);
      probe(32'h0300_1000, k, 0);
    end

    // R12 lock: write would make address 0x10 non-secure
    lock_i = 1;
    cfg_wr(4, 0, 32'h0000_0000);
    lock_i = 0;
    probe(32'h0000_0010, 1, 0);
    probe(m_base[4], 1, 0);
    cfg_wr(4, 0, 32'h0000_0000);
    m_base[4] = 32'h0000_0000;
    probe(32'h0000_0010, 1, 0);   // R12 unlocked write takes effect

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule